// File: doc/BRIEF.md
# Set-Associative Decoded Micro-op Cache

This block sits in a processor front end beside the instruction decoder. It keeps groups of micro-ops that were already decoded, and may already be fused, so that code which runs again does not pass through the decoder a second time. A lookup presents a fetch address. One cycle later the block either returns the whole stored group of up to eight micro-ops with a mask of the valid slots, or reports a miss that tells the decoder path to decode. The decoder then writes its output back through the fill port. The cache treats each slot as opaque: one slot may stand for several original operations.

Storage is 32 sets of 8 ways. Each line holds a valid bit, an address tag, a slot count from 0 to 8 and eight payload slots. A tree pseudo-LRU per set chooses the victim when the set has no free way. A flush input empties the whole cache in one cycle, for example after self-modifying code or a context change. A two-state controller throttles lookups. In `ST_SERVE` it accepts lookups. An accepted lookup that misses takes it to `ST_AWAIT_FILL`, where lookups are refused. It returns to `ST_SERVE` on the next fill or flush.

Top module: `uop_cache`

## Requirements
- R1: After reset no line is valid, `lk_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The set index is address bits [6:2] and the tag is bits [31:7]. Address bits [1:0] are ignored, so two addresses that differ only there find the same line, while a change in a tag bit misses.
- R3: A lookup is accepted on a rising edge where `lk_valid_i` and `lk_ready_o` are 1 and `flush_i` is 0. On a hit, the response registers set `rsp_valid_o`=1, `rsp_hit_o`=1 and `dec_req_o`=0 at that edge, and the whole group is delivered in that single cycle.
- R4: In a hit response, bit i of `rsp_uop_vld_o` is 1 exactly when i is below the stored count, and slot i of `rsp_uops_o` (bits [32i+31:32i]) carries the filled payload. Slots at or above the count read as zero. A fill count above 8 is stored as 8, and a count of 0 is a valid line with an empty mask.
- R5: A miss response has `rsp_valid_o`=1, `rsp_hit_o`=0, `dec_req_o`=1 and an all-zero mask.
- R6: After a miss response `lk_ready_o` stays 0 until a fill or a flush is taken. Lookups offered in that time get no response.
- R7: A fill whose tag already sits in the set overwrites that way in place. Otherwise it takes the lowest-numbered invalid way.
- R8: When all ways of the set are valid, a fill replaces the tree pseudo-LRU victim. The tree is updated on every hit and every fill. After fills to ways 0..7 in order and a hit on way 0, the next fill evicts way 4.
- R9: A flush clears every line in one cycle, together with the replacement state. It takes priority over a fill and a lookup in the same cycle, and both of those are dropped.
- R10: Sets are independent, and one set holds 8 distinct tags at once without losing any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all lines |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup fetch address |
| lk_ready_o | output | 1 | Lookup can be accepted |
| rsp_valid_o | output | 1 | Response to last accepted lookup |
| rsp_hit_o | output | 1 | Response is a hit |
| dec_req_o | output | 1 | Miss: decoder must decode this address |
| rsp_uops_o | output | 256 | Eight 32-bit micro-op slots |
| rsp_uop_vld_o | output | 8 | Valid mask of the slots |
| fill_valid_i | input | 1 | Fill request from the decoder |
| fill_addr_i | input | 32 | Fill address |
| fill_count_i | input | 4 | Number of micro-ops in the group |
| fill_uops_i | input | 256 | Eight 32-bit micro-op slots to store |

## Verification
On every cycle, the assertions check the following. Each response traces back to an accepted lookup. The valid mask is always a contiguous run from slot 0. A miss carries no micro-ops and stalls the lookup side. At most one way matches a tag. A flush leaves no valid line and no response behind it. Only the directed scenarios can show the rest: the exact payload and mask per count, the in-place overwrite, the specific pseudo-LRU victim after a given access history, and the ignored low address bits.

// File: rtl/uc_pkg.sv
package uc_pkg;
    typedef enum logic [0:0] {
        ST_SERVE      = 1'b0,
        ST_AWAIT_FILL = 1'b1
    } uc_state_e;
endpackage

// File: rtl/uc_way_match.sv
module uc_way_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 25,
    localparam int LW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic [WAYS-1:0]       match_o,
    output logic                  hit_o,
    output logic [LW-1:0]         way_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
    end

    assign hit_o = |match_o;

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) way_o = LW'(w);
        end
    end
endmodule

// File: rtl/uc_plru_update.sv
module uc_plru_update #(
    parameter int WAYS = 8,
    localparam int LW  = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree_i,
    input  logic            acc_en_i,
    input  logic [LW-1:0]   acc_way_i,
    output logic [WAYS-2:0] tree_o
);
    // Each node on the path is turned to point away from the accessed way.
    always_comb begin
        int unsigned node;
        node   = 0;
        tree_o = tree_i;
        for (int l = 0; l < LW; l++) begin
            if (acc_en_i) tree_o[node] = ~acc_way_i[LW-1-l];
            node = 2 * node + 1 + int'(acc_way_i[LW-1-l]);
        end
    end
endmodule

// File: rtl/uc_plru_victim.sv
module uc_plru_victim #(
    parameter int WAYS = 8,
    localparam int LW  = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree_i,
    output logic [LW-1:0]   victim_o
);
    always_comb begin
        int unsigned node;
        node     = 0;
        victim_o = '0;
        for (int l = 0; l < LW; l++) begin
            victim_o[LW-1-l] = tree_i[node];
            node = 2 * node + 1 + int'(tree_i[node]);
        end
    end
endmodule

// File: rtl/uop_cache.sv
module uop_cache
    import uc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 8,
    parameter int SLOTS  = 8,
    parameter int UOP_W  = 32,
    parameter int OFF_W  = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int LW    = $clog2(WAYS),
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int GRP_W = SLOTS * UOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              lk_ready_o,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic              dec_req_o,
    output logic [GRP_W-1:0]  rsp_uops_o,
    output logic [SLOTS-1:0]  rsp_uop_vld_o,
    input  logic              fill_valid_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [CNT_W-1:0]  fill_count_i,
    input  logic [GRP_W-1:0]  fill_uops_i
);
    // ---------------- storage ----------------
    logic [WAYS-1:0]  line_vld_q [SETS];
    logic [WAYS-2:0]  plru_q     [SETS];
    logic [TAG_W-1:0] line_tag_q [SETS][WAYS];
    logic [CNT_W-1:0] line_cnt_q [SETS][WAYS];
    logic [GRP_W-1:0] line_uop_q [SETS][WAYS];

    uc_state_e state_q, state_d;

    // ---------------- address split ----------------
    logic [IDX_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    assign lk_set = lk_addr_i[OFF_W +: IDX_W];
    assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
    assign fl_set = fill_addr_i[OFF_W +: IDX_W];
    assign fl_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

    logic lk_accept, fill_accept;
    assign lk_accept   = lk_valid_i && lk_ready_o && !flush_i;
    assign fill_accept = fill_valid_i && !flush_i;

    // ---------------- tag match ----------------
    logic [WAYS*TAG_W-1:0] lk_tags_flat, fl_tags_flat;
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags_flat[w*TAG_W +: TAG_W] = line_tag_q[lk_set][w];
            fl_tags_flat[w*TAG_W +: TAG_W] = line_tag_q[fl_set][w];
        end
    end

    logic [WAYS-1:0] lk_match, fl_match;
    logic            lk_hit, fl_hit;
    logic [LW-1:0]   lk_way, fl_hit_way;

    uc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld_i(line_vld_q[lk_set]), .tags_i(lk_tags_flat), .tag_i(lk_tag),
        .match_o(lk_match), .hit_o(lk_hit), .way_o(lk_way)
    );
    uc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .vld_i(line_vld_q[fl_set]), .tags_i(fl_tags_flat), .tag_i(fl_tag),
        .match_o(fl_match), .hit_o(fl_hit), .way_o(fl_hit_way)
    );

    // ---------------- replacement ----------------
    logic [WAYS-2:0] lk_tree_nxt, fl_tree_base, fl_tree_nxt;
    logic [LW-1:0]   fl_victim, fl_free_way, fl_way;
    logic            fl_free_any;

    uc_plru_update #(.WAYS(WAYS)) u_lk_plru (
        .tree_i(plru_q[lk_set]), .acc_en_i(lk_accept && lk_hit),
        .acc_way_i(lk_way), .tree_o(lk_tree_nxt)
    );

    // A same-cycle hit to the fill's set is folded in before the fill update.
    assign fl_tree_base = (lk_accept && lk_hit && (lk_set == fl_set))
                        ? lk_tree_nxt : plru_q[fl_set];

    uc_plru_victim #(.WAYS(WAYS)) u_fl_victim (
        .tree_i(fl_tree_base), .victim_o(fl_victim)
    );

    always_comb begin
        fl_free_any = 1'b0;
        fl_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!line_vld_q[fl_set][w]) begin
                fl_free_any = 1'b1;
                fl_free_way = LW'(w);
            end
        end
    end

    assign fl_way = fl_hit ? fl_hit_way : (fl_free_any ? fl_free_way : fl_victim);

    uc_plru_update #(.WAYS(WAYS)) u_fl_plru (
        .tree_i(fl_tree_base), .acc_en_i(fill_accept),
        .acc_way_i(fl_way), .tree_o(fl_tree_nxt)
    );

    logic [CNT_W-1:0] fl_cnt;
    assign fl_cnt = (int'(fill_count_i) > SLOTS) ? CNT_W'(SLOTS) : fill_count_i;

    // ---------------- line state ----------------
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            for (int s = 0; s < SETS; s++) begin
                line_vld_q[s] <= '0;
                plru_q[s]     <= '0;
            end
        end else begin
            if (lk_accept && lk_hit) plru_q[lk_set] <= lk_tree_nxt;
            if (fill_accept) begin
                line_vld_q[fl_set][fl_way] <= 1'b1;
                plru_q[fl_set]             <= fl_tree_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_accept) begin
            line_tag_q[fl_set][fl_way] <= fl_tag;
            line_cnt_q[fl_set][fl_way] <= fl_cnt;
            line_uop_q[fl_set][fl_way] <= fill_uops_i;
        end
    end

    // ---------------- read-out ----------------
    logic [CNT_W-1:0] rd_cnt;
    logic [GRP_W-1:0] rd_uops, hit_uops;
    logic [SLOTS-1:0] hit_mask;
    assign rd_cnt  = line_cnt_q[lk_set][lk_way];
    assign rd_uops = line_uop_q[lk_set][lk_way];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            hit_mask[i] = (i < int'(rd_cnt));
            hit_uops[i*UOP_W +: UOP_W] = hit_mask[i] ? rd_uops[i*UOP_W +: UOP_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o   <= 1'b0;
            rsp_hit_o     <= 1'b0;
            dec_req_o     <= 1'b0;
            rsp_uop_vld_o <= '0;
            rsp_uops_o    <= '0;
        end else begin
            rsp_valid_o   <= lk_accept;
            rsp_hit_o     <= lk_accept && lk_hit;
            dec_req_o     <= lk_accept && !lk_hit;
            rsp_uop_vld_o <= (lk_accept && lk_hit) ? hit_mask : '0;
            rsp_uops_o    <= (lk_accept && lk_hit) ? hit_uops : '0;
        end
    end

    // ---------------- controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERVE:      if (lk_accept && !lk_hit)        state_d = ST_AWAIT_FILL;
            ST_AWAIT_FILL: if (flush_i || fill_valid_i)     state_d = ST_SERVE;
            default:                                         state_d = ST_SERVE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SERVE:      lk_ready_o = 1'b1;
            ST_AWAIT_FILL: lk_ready_o = 1'b0;
            default:       lk_ready_o = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    logic any_line_vld;
    always_comb begin
        any_line_vld = 1'b0;
        for (int s = 0; s < SETS; s++) any_line_vld = any_line_vld | (|line_vld_q[s]);
    end

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(lk_valid_i && lk_ready_o && !flush_i)); // R3
    AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (((rsp_uop_vld_o + SLOTS'(1)) & rsp_uop_vld_o) == '0)); // R4
    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req_o |-> (!rsp_hit_o && rsp_uop_vld_o == '0)); // R5
    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req_o |-> !lk_ready_o); // R6
    AST_ONE_WAY_LK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_accept |-> $onehot0(lk_match)); // R7
    AST_ONE_WAY_FL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |-> $onehot0(fl_match)); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !any_line_vld); // R9
    AST_FLUSH_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !rsp_valid_o); // R9
endmodule

// File: tb/sim_uop_cache.sv
module sim_uop_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int UW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic lk_valid_i = 1'b0;
    logic [31:0] lk_addr_i = '0;
    logic lk_ready_o, rsp_valid_o, rsp_hit_o, dec_req_o;
    logic [NS*UW-1:0] rsp_uops_o;
    logic [NS-1:0] rsp_uop_vld_o;
    logic fill_valid_i = 1'b0;
    logic [31:0] fill_addr_i = '0;
    logic [3:0] fill_count_i = '0;
    logic [NS*UW-1:0] fill_uops_i = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uop_cache u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_ready_o(lk_ready_o),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .dec_req_o(dec_req_o),
        .rsp_uops_o(rsp_uops_o), .rsp_uop_vld_o(rsp_uop_vld_o),
        .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
        .fill_count_i(fill_count_i), .fill_uops_i(fill_uops_i)
    );

    function automatic logic [31:0] mk_addr(int set, int tag);
        return (32'(tag) << 7) | (32'(set) << 2);
    endfunction

    function automatic logic [NS*UW-1:0] mk_grp(int set, int tag, int salt);
        logic [NS*UW-1:0] g;
        for (int i = 0; i < NS; i++) g[i*UW +: UW] = {8'(salt), 8'(set), 8'(tag), 8'(i)};
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input logic [NS*UW-1:0] act,
                         input logic [NS*UW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] a, input int cnt, input int set, input int tag,
                           input int salt);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_addr_i = a; fill_count_i = 4'(cnt);
        fill_uops_i = mk_grp(set, tag, salt);
        @(negedge clk);
        fill_valid_i = 1'b0;
    endtask

    task automatic release_wait();
        do_fill(mk_addr(31, 1), 1, 31, 1, 0);
    endtask

    task automatic do_lookup(input logic [31:0] a);
        @(negedge clk);
        lk_valid_i = 1'b1; lk_addr_i = a;
        @(negedge clk);
        lk_valid_i = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] a, input int set, input int tag, input int cnt,
                              input int salt, input string req);
        logic [NS*UW-1:0] exp_u;
        logic [NS-1:0] exp_m;
        int n;
        n = (cnt > NS) ? NS : cnt;
        exp_u = mk_grp(set, tag, salt);
        for (int i = 0; i < NS; i++) begin
            exp_m[i] = (i < n);
            if (i >= n) exp_u[i*UW +: UW] = '0;
        end
        do_lookup(a);
        check(rsp_valid_o && rsp_hit_o && !dec_req_o, req, {rsp_valid_o, rsp_hit_o, dec_req_o}, 3'b110);
        check(rsp_uop_vld_o == exp_m, req, rsp_uop_vld_o, exp_m);
        check(rsp_uops_o == exp_u, req, rsp_uops_o, exp_u);
    endtask

    task automatic expect_miss(input logic [31:0] a, input string req);
        do_lookup(a);
        check(rsp_valid_o && !rsp_hit_o && dec_req_o && rsp_uop_vld_o == '0, req,
              {rsp_valid_o, rsp_hit_o, dec_req_o, rsp_uop_vld_o}, {3'b101, 8'h00});
    endtask

    // R1 R5 R6 R3 R4 R2
    task automatic t_reset_and_miss();
        check(lk_ready_o == 1'b1 && rsp_valid_o == 1'b0, "R1 reset state",
              {lk_ready_o, rsp_valid_o}, 2'b10);
        expect_miss(mk_addr(1, 3), "R1/R5 cold miss");
        check(lk_ready_o == 1'b0, "R6 stall after miss", lk_ready_o, 1'b0);
        do_lookup(mk_addr(1, 3));
        check(rsp_valid_o == 1'b0, "R6 lookup ignored while waiting", rsp_valid_o, 1'b0);
        do_fill(mk_addr(1, 3), 3, 1, 3, 1);
        check(lk_ready_o == 1'b1, "R6 ready after fill", lk_ready_o, 1'b1);
        expect_hit(mk_addr(1, 3), 1, 3, 3, 1, "R3/R4 hit three slots");
        expect_hit(mk_addr(1, 3) | 32'h3, 1, 3, 3, 1, "R2 low bits ignored");
        expect_miss(mk_addr(1, 2), "R2 tag bit differs");
        release_wait();
    endtask

    // R4
    task automatic t_counts();
        do_fill(mk_addr(2, 1), 8, 2, 1, 2);
        do_fill(mk_addr(2, 2), 0, 2, 2, 2);
        do_fill(mk_addr(2, 3), 12, 2, 3, 2);
        expect_hit(mk_addr(2, 1), 2, 1, 8, 2, "R4 full group");
        expect_hit(mk_addr(2, 2), 2, 2, 0, 2, "R4 empty group");
        expect_hit(mk_addr(2, 3), 2, 3, 8, 2, "R4 count clamped");
    endtask

    // R7 R10
    task automatic t_overwrite();
        do_fill(mk_addr(3, 1), 2, 3, 1, 5);
        do_fill(mk_addr(3, 1), 5, 3, 1, 6);
        expect_hit(mk_addr(3, 1), 3, 1, 5, 6, "R7 overwrite in place");
        for (int t = 2; t <= 8; t++) do_fill(mk_addr(3, t), t % 9, 3, t, 7);
        expect_hit(mk_addr(3, 1), 3, 1, 5, 6, "R7/R10 no duplicate way used");
        for (int t = 2; t <= 8; t++) expect_hit(mk_addr(3, t), 3, t, t % 9, 7, "R10 eight ways kept");
    endtask

    // R8 R10
    task automatic t_plru();
        for (int t = 10; t <= 17; t++) do_fill(mk_addr(5, t), 4, 5, t, t);
        expect_hit(mk_addr(5, 10), 5, 10, 4, 10, "R8 touch way 0");
        do_fill(mk_addr(5, 18), 6, 5, 18, 18);
        expect_miss(mk_addr(5, 14), "R8 way 4 evicted");
        release_wait();
        expect_hit(mk_addr(5, 18), 5, 18, 6, 18, "R8 new line present");
        for (int t = 10; t <= 17; t++) begin
            if (t != 14) expect_hit(mk_addr(5, t), 5, t, 4, t, "R8 other ways kept");
        end
        expect_hit(mk_addr(3, 1), 3, 1, 5, 6, "R10 other set untouched");
    endtask

    // R9 R6
    task automatic t_flush();
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
        expect_miss(mk_addr(5, 10), "R9 flush clears lines");
        release_wait();
        expect_miss(mk_addr(3, 1), "R9 flush clears other set");
        release_wait();
        @(negedge clk);
        flush_i = 1'b1; fill_valid_i = 1'b1; fill_addr_i = mk_addr(6, 1);
        fill_count_i = 4'd2; fill_uops_i = mk_grp(6, 1, 9);
        @(negedge clk);
        flush_i = 1'b0; fill_valid_i = 1'b0;
        expect_miss(mk_addr(6, 1), "R9 fill dropped under flush");
        check(lk_ready_o == 1'b0, "R6 waiting before flush", lk_ready_o, 1'b0);
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
        check(lk_ready_o == 1'b1, "R9/R6 flush releases wait", lk_ready_o, 1'b1);
        do_fill(mk_addr(6, 1), 2, 6, 1, 9);
        @(negedge clk);
        flush_i = 1'b1; lk_valid_i = 1'b1; lk_addr_i = mk_addr(6, 1);
        @(negedge clk);
        flush_i = 1'b0; lk_valid_i = 1'b0;
        check(rsp_valid_o == 1'b0, "R9 lookup dropped under flush", rsp_valid_o, 1'b0);
        expect_miss(mk_addr(6, 1), "R9 line gone after flush");
        release_wait();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_miss();
        t_counts();
        t_overwrite();
        t_plru();
        t_flush();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired (all requirements)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule